// File: doc/BRIEF.md
# Multiplexed Bus Cycle Sequencer

This block runs one bus transaction at a time through a fixed phase sequence: an address phase (T1), a status phase (T2), a data phase (T3), any number of one-clock wait phases, and a closing phase (T4). When no transfer is pending it rests in idle. In T1 it raises an address-latch-enable pulse and puts the full address on a shared 20-line address/status bus. It also drives a 3-bit cycle-type code, so that an external decoder can tell what kind of transaction is starting. From T2 onward the top four lines of the shared bus stop carrying address. They carry the segment selector and the interrupt-enable flag instead, and the low sixteen lines keep the address offset.

A requester holds `req_valid` with a type, an address, a segment selector and an interrupt-enable bit. The request is taken in idle, or in T4 of the cycle that is ending, and T1 follows on the next clock. Once taken, the request is held inside the block, so the requester may change or drop its inputs. A `ready` input stretches the data phase. A `done` strobe in T4 marks the end of each transaction. The cycle-type code falls back to the passive code as soon as the status phase is over, and stays passive through idle.

Top module: `bus_cycle_seq`

## Requirements
- R1: After reset is released and before any request, `stat` is 3'b111, `ale` is 0, `done` is 0 and `ad` is all zeros.
- R2: `ale` is 1 for exactly one clock per transaction: the clock right after the request is taken (T1). In that clock, a non-port transaction drives the full 20-bit request address on `ad`.
- R3: `stat` equals the request type in T1 and in T2. It is 3'b111 in T3, in wait phases, in T4 and in idle. Type codes: 000 interrupt acknowledge, 001 port read, 010 port write, 011 halt, 100 code fetch, 101 memory read, 110 memory write.
- R4: In T2, T3, wait phases and T4, `ad[19]` is 0, `ad[18]` is the interrupt-enable flag, `ad[17:16]` is the segment code (00 extra, 01 stack, 10 code/none, 11 data), and `ad[15:0]` is the low 16 address bits.
- R5: For port types (001, 010), `ad[19:16]` is 0 in T1 and `ad[15:0]` carries the 16-bit port address.
- R6: `ready` is sampled at the end of T3 and at the end of each wait phase. While it is 0, one wait phase is added. T4 comes in the clock after `ready` is sampled 1, so a transaction lasts 4 + N clocks from T1 to T4 for N waits.
- R7: `done` is 1 only in T4, for one clock per transaction.
- R8: A valid request present during T4 starts T1 on the next clock, with no idle clock between the two transactions.
- R9: With no request pending, the clock after T4 is idle: `ad` is zero, `ale` and `done` are 0, and `stat` is 3'b111.
- R10: A request of type 3'b111 is ignored both in idle and in T4. No transaction starts, and the outputs show idle on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Transfer request present |
| req_kind | input | 3 | Transaction type code |
| req_addr | input | 20 | Memory address, or port address in bits 15:0 |
| req_seg | input | 2 | Segment selector code |
| req_ie | input | 1 | Interrupt-enable flag to report |
| ready | input | 1 | Target ready; low adds wait phases |
| ad | output | 20 | Multiplexed address/status lines |
| ale | output | 1 | Address latch enable, high in T1 |
| stat | output | 3 | Cycle-type status code |
| done | output | 1 | End-of-transaction strobe in T4 |

## Verification
The hardest situation to reach is a transaction that starts in T4 of the one before it, after a run of wait phases. This is the case where a stale `ready`, a stale status nibble or a missed restart would show. The bench sweeps every type, segment code, interrupt-enable value and a wait count of 0 to 2. On alternating passes it presents the next request during T4 or lets the sequencer fall to idle, so back-to-back restarts follow every wait length. Passive-type requests are offered both in idle and in T4.

// File: rtl/bus_seq_pkg.sv
package bus_seq_pkg;
  localparam int KIND_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_T1   = 3'd1,
    PH_T2   = 3'd2,
    PH_T3   = 3'd3,
    PH_TW   = 3'd4,
    PH_T4   = 3'd5
  } phase_e;

  localparam logic [KIND_W-1:0] KIND_PORT_RD = 3'b001;
  localparam logic [KIND_W-1:0] KIND_PORT_WR = 3'b010;
  localparam logic [KIND_W-1:0] KIND_NONE    = 3'b111;

  function automatic logic is_port_kind(input logic [KIND_W-1:0] k);
    return (k == KIND_PORT_RD) || (k == KIND_PORT_WR);
  endfunction

  function automatic logic is_real_kind(input logic [KIND_W-1:0] k);
    return k != KIND_NONE;
  endfunction
endpackage

// File: rtl/bus_seq_phase_fsm.sv
module bus_seq_phase_fsm
  import bus_seq_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [KIND_W-1:0] req_kind,
  input  logic              ready,
  output phase_e            phase,
  output logic              accept
);
  phase_e phase_nx;
  logic   open_slot;

  assign open_slot = (phase == PH_IDLE) || (phase == PH_T4);
  assign accept    = open_slot && req_valid && is_real_kind(req_kind);

  always_comb begin
    phase_nx = phase;
    unique case (phase)
      PH_IDLE: phase_nx = accept ? PH_T1 : PH_IDLE;
      PH_T1:   phase_nx = PH_T2;
      PH_T2:   phase_nx = PH_T3;
      PH_T3:   phase_nx = ready ? PH_T4 : PH_TW;
      PH_TW:   phase_nx = ready ? PH_T4 : PH_TW;
      PH_T4:   phase_nx = accept ? PH_T1 : PH_IDLE;
      default: phase_nx = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IDLE;
    else        phase <= phase_nx;
  end
endmodule

// File: rtl/bus_seq_req_reg.sv
module bus_seq_req_reg
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept,
  input  logic [KIND_W-1:0] in_kind,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [SEG_W-1:0]  in_seg,
  input  logic              in_ie,
  output logic [KIND_W-1:0] kind_q,
  output logic [ADDR_W-1:0] addr_q,
  output logic [SEG_W-1:0]  seg_q,
  output logic              ie_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      kind_q <= KIND_NONE;
      addr_q <= '0;
      seg_q  <= '0;
      ie_q   <= 1'b0;
    end else if (accept) begin
      kind_q <= in_kind;
      addr_q <= in_addr;
      seg_q  <= in_seg;
      ie_q   <= in_ie;
    end
  end
endmodule

// File: rtl/bus_seq_ad_mux.sv
module bus_seq_ad_mux
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int PORT_W = 16,
  parameter int SEG_W  = 2
) (
  input  phase_e            phase,
  input  logic [KIND_W-1:0] kind_q,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [SEG_W-1:0]  seg_q,
  input  logic              ie_q,
  output logic [ADDR_W-1:0] ad,
  output logic              ale,
  output logic [KIND_W-1:0] stat,
  output logic              done
);
  localparam int UPPER_W = ADDR_W - PORT_W;

  function automatic logic [ADDR_W-1:0] addr_lines(input logic [KIND_W-1:0] k,
                                                   input logic [ADDR_W-1:0] a);
    if (is_port_kind(k)) return {{UPPER_W{1'b0}}, a[PORT_W-1:0]};
    return a;
  endfunction

  function automatic logic [ADDR_W-1:0] status_lines(input logic [ADDR_W-1:0] a,
                                                     input logic [SEG_W-1:0] s,
                                                     input logic ie);
    logic [UPPER_W-1:0] nib;
    nib = UPPER_W'({1'b0, ie, s});
    return {nib, a[PORT_W-1:0]};
  endfunction

  always_comb begin
    ad   = '0;
    stat = KIND_NONE;
    unique case (phase)
      PH_T1: begin
        ad   = addr_lines(kind_q, addr_q);
        stat = kind_q;
      end
      PH_T2: begin
        ad   = status_lines(addr_q, seg_q, ie_q);
        stat = kind_q;
      end
      PH_T3, PH_TW, PH_T4: ad = status_lines(addr_q, seg_q, ie_q);
      default: ad = '0;
    endcase
  end

  assign ale  = (phase == PH_T1);
  assign done = (phase == PH_T4);
endmodule

// File: rtl/bus_cycle_seq.sv
module bus_cycle_seq
  import bus_seq_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int PORT_W = 16,
  parameter int SEG_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [2:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [SEG_W-1:0]  req_seg,
  input  logic              req_ie,
  input  logic              ready,
  output logic [ADDR_W-1:0] ad,
  output logic              ale,
  output logic [2:0]        stat,
  output logic              done
);
  phase_e            phase;
  logic              accept;
  logic [KIND_W-1:0] kind_q;
  logic [ADDR_W-1:0] addr_q;
  logic [SEG_W-1:0]  seg_q;
  logic              ie_q;

  logic in_idle, in_t2, in_t3, in_tw, in_t4;
  assign in_idle = (phase == PH_IDLE);
  assign in_t2   = (phase == PH_T2);
  assign in_t3   = (phase == PH_T3);
  assign in_tw   = (phase == PH_TW);
  assign in_t4   = (phase == PH_T4);

  bus_seq_phase_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .ready(ready), .phase(phase), .accept(accept)
  );

  bus_seq_req_reg #(.ADDR_W(ADDR_W), .SEG_W(SEG_W)) u_req (
    .clk(clk), .rst_n(rst_n), .accept(accept), .in_kind(req_kind),
    .in_addr(req_addr), .in_seg(req_seg), .in_ie(req_ie),
    .kind_q(kind_q), .addr_q(addr_q), .seg_q(seg_q), .ie_q(ie_q)
  );

  bus_seq_ad_mux #(.ADDR_W(ADDR_W), .PORT_W(PORT_W), .SEG_W(SEG_W)) u_mux (
    .phase(phase), .kind_q(kind_q), .addr_q(addr_q), .seg_q(seg_q), .ie_q(ie_q),
    .ad(ad), .ale(ale), .stat(stat), .done(done)
  );
endmodule

// File: rtl/bus_cycle_seq_chk.sv
module bus_cycle_seq_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [2:0]        req_kind,
  input logic              ready,
  input logic [ADDR_W-1:0] ad,
  input logic              ale,
  input logic [2:0]        stat,
  input logic              done,
  input logic              accept,
  input logic              in_idle,
  input logic              in_t2,
  input logic              in_t3,
  input logic              in_tw,
  input logic              in_t4
);
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> !ale); // R2
  AST_ALE_REAL_KIND: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> stat != 3'b111); // R3
  AST_KIND_HELD_T2: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (in_t2 && stat == $past(stat))); // R3
  AST_PASSIVE_AFTER_T2: assert property (@(posedge clk) disable iff (!rst_n)
    in_t2 |=> stat == 3'b111); // R3
  AST_TOP_LINE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_t2 || in_t3 || in_tw || in_t4) |-> !ad[ADDR_W-1]); // R4
  AST_WAIT_ON_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_t3 || in_tw) && !ready) |=> in_tw); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R7
  AST_RESTART_T1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_t4 && accept) |=> ale); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    in_idle |-> (ad == '0 && !ale && !done && stat == 3'b111)); // R9
  AST_NONE_KIND_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    ((in_idle || in_t4) && req_valid && req_kind == 3'b111) |=> !ale); // R10
endmodule

bind bus_cycle_seq bus_cycle_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
  .ready(ready), .ad(ad), .ale(ale), .stat(stat), .done(done),
  .accept(accept), .in_idle(in_idle), .in_t2(in_t2), .in_t3(in_t3),
  .in_tw(in_tw), .in_t4(in_t4)
);

// File: tb/bus_cycle_seq_test.sv
`timescale 1ns/1ps
module bus_cycle_seq_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_kind = 3'b111;
  logic [19:0] req_addr = '0;
  logic [1:0]  req_seg = '0;
  logic        req_ie = 1'b0;
  logic        ready = 1'b1;
  logic [19:0] ad;
  logic        ale;
  logic [2:0]  stat;
  logic        done;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  bus_cycle_seq uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_addr(req_addr), .req_seg(req_seg), .req_ie(req_ie), .ready(ready),
    .ad(ad), .ale(ale), .stat(stat), .done(done)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [31:0] exp_t1(input int k, input logic [19:0] a);
    if (k == 1 || k == 2) return 32'(a) % 32'h10000;
    return 32'(a);
  endfunction

  function automatic logic [31:0] exp_late(input logic [19:0] a, input int s, input int ie);
    return ie * 32'h40000 + s * 32'h10000 + 32'(a) % 32'h10000;
  endfunction

  task automatic check_idle(input string req);
    chk(req, 32'(ad), 0);
    chk(req, 32'(ale), 0);
    chk(req, 32'(done), 0);
    chk(req, 32'(stat), 7);
  endtask

  // Call at a negedge in idle or T4; returns at the negedge of T4.
  task automatic run_cycle(input int k, input logic [19:0] a, input int s,
                           input int ie, input int nw);
    req_valid = 1'b1;
    req_kind  = 3'(k);
    req_addr  = a;
    req_seg   = 2'(s);
    req_ie    = 1'(ie);
    step();
    chk("R2 ale in T1", 32'(ale), 1);
    chk("R3 type in T1", 32'(stat), 32'(k));
    chk((k == 1 || k == 2) ? "R5 port address" : "R2 address in T1", 32'(ad), exp_t1(k, a));
    chk("R7 no done in T1", 32'(done), 0);
    req_valid = 1'b0;
    req_addr  = ~a;
    req_seg   = ~2'(s);
    req_ie    = ~1'(ie);
    ready     = (nw == 0);
    step();
    chk("R2 ale low in T2", 32'(ale), 0);
    chk("R3 type in T2", 32'(stat), 32'(k));
    chk("R4 status lines T2", 32'(ad), exp_late(a, s, ie));
    step();
    chk("R3 passive in T3", 32'(stat), 7);
    chk("R4 status lines T3", 32'(ad), exp_late(a, s, ie));
    chk("R7 no done in T3", 32'(done), 0);
    for (int i = 0; i < nw; i++) begin
      step();
      chk("R6 wait phase no done", 32'(done), 0);
      chk("R6 wait phase passive", 32'(stat), 7);
      chk("R4 status lines wait", 32'(ad), exp_late(a, s, ie));
      ready = (i == nw - 1);
    end
    step();
    chk("R7 done in T4", 32'(done), 1);
    chk("R3 passive in T4", 32'(stat), 7);
    chk("R4 status lines T4", 32'(ad), exp_late(a, s, ie));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 reset state");

    // R10: passive-type request in idle is ignored
    req_valid = 1'b1;
    req_kind  = 3'b111;
    req_addr  = 20'hABCDE;
    step();
    check_idle("R10 passive type in idle");
    req_valid = 1'b0;
    step();

    for (int k = 0; k < 7; k++)
      for (int s = 0; s < 4; s++)
        for (int ie = 0; ie < 2; ie++)
          for (int w = 0; w < 3; w++) begin
            logic [19:0] a;
            a = 20'((k * 32'h23456 + s * 32'h11111 + w * 32'h0F0F + ie * 32'h80001) % 32'h100000);
            run_cycle(k, a, s, ie, w);
            if (((s + w + k) % 2) == 1) begin
              req_valid = 1'b0;
              step();
              check_idle("R9 idle after T4");
            end
            // else the next run_cycle starts from T4 (R8 back-to-back)
          end

    // R8: explicit back-to-back check, then R10 in T4
    run_cycle(5, 20'hF0F0F, 3, 1, 1);
    run_cycle(1, 20'h9ABCD, 0, 0, 0);
    chk("R8 chained done", 32'(done), 1);
    req_valid = 1'b1;
    req_kind  = 3'b111;
    step();
    check_idle("R10 passive type in T4");
    req_valid = 1'b0;
    step();
    check_idle("R9 stays idle");

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule